// File: doc/BRIEF.md
# Polarity and Bit-Order Reverser

This block rearranges a 20-bit parallel word that travels through a serial-link coding datapath. The word holds two 10-bit symbol slots: slot 0 in bits [9:0] and slot 1 in bits [19:10]. The block can do any mix of three things to the word. It can complement its bits, mirror the bit order inside each symbol, and exchange the two slots. The same block serves the transmit path and the receive path. Because every operation undoes itself, a receiver set up like the transmitter recovers the original word.

Two static settings choose how a slot is read. In coded mode each slot is a full 10-bit symbol. In byte mode the low 8 bits of a slot hold a data byte and its top two bits are side bits. Side bits are never complemented and never mirrored. In single-symbol width only slot 0 is active and slot 1 passes straight through. A bypass setting overrides every other setting. The output is registered with one cycle of latency, and a valid flag travels with the data.

Top module: `polarity_order_rev`

## Requirements
- R1: While reset is high at a clock edge, out_valid and out_data are zero after that edge.
- R2: out_data and out_valid show the result for the inputs sampled at the previous rising edge, and out_valid equals the in_valid of that edge.
- R3: With cfg_bypass = 1, out_data equals in_data, whatever the other settings are.
- R4: In coded mode (cfg_byte_mode = 0), cfg_invert complements every bit of the active width: bits [19:0] when cfg_dual = 1, and bits [9:0] when cfg_dual = 0.
- R5: In coded mode, cfg_bitrev mirrors each active 10-bit slot, so output bit k of the slot takes input bit 9-k.
- R6: In byte mode (cfg_byte_mode = 1), cfg_invert complements only bits [7:0] and [17:10]. Side bits [9:8] and [19:18] are unchanged.
- R7: In byte mode, cfg_bitrev mirrors bits [7:0] and, separately, bits [17:10] (output bit k of the byte takes input bit 7-k). Side bits keep their positions.
- R8: With cfg_dual = 1 and cfg_swap = 1, the two 10-bit slots trade places as whole slots, side bits included.
- R9: With cfg_dual = 0, bits [19:10] pass through unchanged, and cfg_swap has no effect.
- R10: The operations apply in a fixed order: inversion, then bit mirroring, then slot exchange. Sending the output through the block a second time with the same settings returns the original word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks in_data as valid |
| in_data | input | 20 | Input word; slot 0 is [9:0], slot 1 is [19:10] |
| cfg_bypass | input | 1 | Pass the data through unchanged |
| cfg_invert | input | 1 | Complement the active bits |
| cfg_bitrev | input | 1 | Mirror the bit order inside each active symbol |
| cfg_swap | input | 1 | Exchange the two slots (two-symbol width only) |
| cfg_byte_mode | input | 1 | 1: byte plus side bits per slot; 0: full 10-bit symbols |
| cfg_dual | input | 1 | 1: two-symbol width; 0: single-symbol width |
| out_valid | output | 1 | Registered copy of in_valid |
| out_data | output | 20 | Registered, transformed word |

## Verification
The bench runs all 64 settings of the six configuration inputs. For each setting it drives walking-one words, all zeros, all ones and several mixed words. A walking one shows exactly where each single bit ends up, which separates the mirroring inside a slot from the slot exchange and shows whether side bits moved. All zeros and all ones show which bits were complemented, which separates the byte-mode masks from full-width inversion. The bench then feeds each output back in with the same settings to check that the original word comes back. It toggles in_valid from one vector to the next to check that the flag travels alongside the data.

// File: rtl/prt_pkg.sv
package prt_pkg;
  parameter int SLOT_W = 10;
  parameter int BYTE_W = 8;
  localparam int NSLOT  = 2;
  localparam int WORD_W = SLOT_W * NSLOT;
  localparam int SIDE_W = SLOT_W - BYTE_W;

  typedef struct packed {
    logic bypass;
    logic invert;
    logic bitrev;
    logic swap;
    logic byte_mode;
    logic dual;
  } prt_cfg_t;

  function automatic logic [SLOT_W-1:0] active_mask(input logic byte_mode);
    logic [SLOT_W-1:0] m;
    for (int i = 0; i < SLOT_W; i++)
      m[i] = byte_mode ? (i < BYTE_W) : 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/prt_slot_xform.sv
module prt_slot_xform
  import prt_pkg::*;
(
  input  logic [SLOT_W-1:0] slot_in,
  input  logic              do_invert,
  input  logic              do_bitrev,
  input  logic              byte_mode,
  output logic [SLOT_W-1:0] slot_out
);
  logic [SLOT_W-1:0] flipped;
  logic [SLOT_W-1:0] mirrored;

  always_comb begin
    flipped = slot_in ^ (do_invert ? active_mask(byte_mode) : '0);
  end

  genvar k;
  generate
    for (k = 0; k < SLOT_W; k++) begin : g_bit
      if (k < BYTE_W) begin : g_data
        assign mirrored[k] = byte_mode ? flipped[BYTE_W-1-k] : flipped[SLOT_W-1-k];
      end else begin : g_side
        assign mirrored[k] = byte_mode ? flipped[k] : flipped[SLOT_W-1-k];
      end
    end
  endgenerate

  assign slot_out = do_bitrev ? mirrored : flipped;
endmodule

// File: rtl/prt_slot_swap.sv
module prt_slot_swap
  import prt_pkg::*;
(
  input  logic [WORD_W-1:0] word_in,
  input  logic              do_swap,
  output logic [WORD_W-1:0] word_out
);
  logic [WORD_W-1:0] exchanged;

  genvar s;
  generate
    for (s = 0; s < NSLOT; s++) begin : g_slot
      assign exchanged[s*SLOT_W +: SLOT_W] = word_in[(NSLOT-1-s)*SLOT_W +: SLOT_W];
    end
  endgenerate

  assign word_out = do_swap ? exchanged : word_in;
endmodule

// File: rtl/polarity_order_rev.sv
module polarity_order_rev
  import prt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              cfg_bypass,
  input  logic              cfg_invert,
  input  logic              cfg_bitrev,
  input  logic              cfg_swap,
  input  logic              cfg_byte_mode,
  input  logic              cfg_dual,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);
  prt_cfg_t          cfg;
  logic [WORD_W-1:0] slot_stage;
  logic [WORD_W-1:0] swap_stage;
  logic [WORD_W-1:0] next_data;
  logic              armed;

  assign cfg = '{bypass: cfg_bypass, invert: cfg_invert, bitrev: cfg_bitrev,
                 swap: cfg_swap, byte_mode: cfg_byte_mode, dual: cfg_dual};

  genvar s;
  generate
    for (s = 0; s < NSLOT; s++) begin : g_lane
      logic en;
      if (s == 0) begin : g_base
        assign en = 1'b1;
      end else begin : g_upper
        assign en = cfg.dual;
      end
      prt_slot_xform u_xform (
        .slot_in   (in_data[s*SLOT_W +: SLOT_W]),
        .do_invert (cfg.invert & en),
        .do_bitrev (cfg.bitrev & en),
        .byte_mode (cfg.byte_mode),
        .slot_out  (slot_stage[s*SLOT_W +: SLOT_W])
      );
    end
  endgenerate

  prt_slot_swap u_swap (
    .word_in  (slot_stage),
    .do_swap  (cfg.swap & cfg.dual),
    .word_out (swap_stage)
  );

  assign next_data = cfg.bypass ? in_data : swap_stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      armed     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_data  <= next_data;
      armed     <= 1'b1;
    end
  end

  assert_valid_tracks_R2: assert property (@(posedge clk) disable iff (rst)
    armed |-> out_valid == $past(in_valid));

  assert_bypass_identity_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(cfg_bypass)) |-> out_data == $past(in_data));

  assert_upper_passthru_R9: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(!cfg_bypass && !cfg_dual))
      |-> out_data[WORD_W-1:SLOT_W] == $past(in_data[WORD_W-1:SLOT_W]));

  assert_side_bits_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(!cfg_bypass && cfg_byte_mode && !(cfg_dual && cfg_swap)))
      |-> (out_data[SLOT_W-1:BYTE_W] == $past(in_data[SLOT_W-1:BYTE_W]) &&
           out_data[WORD_W-1:SLOT_W+BYTE_W] == $past(in_data[WORD_W-1:SLOT_W+BYTE_W])));

  assert_slot_exchange_R8: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(!cfg_bypass && cfg_dual && cfg_swap && !cfg_invert && !cfg_bitrev))
      |-> (out_data[SLOT_W-1:0] == $past(in_data[WORD_W-1:SLOT_W]) &&
           out_data[WORD_W-1:SLOT_W] == $past(in_data[SLOT_W-1:0])));
endmodule

// File: tb/polarity_order_rev_bench.sv
module polarity_order_rev_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [19:0] in_data;
  logic        cfg_bypass, cfg_invert, cfg_bitrev, cfg_swap, cfg_byte_mode, cfg_dual;
  logic        out_valid;
  logic [19:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  polarity_order_rev u_polarity_order_rev (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .cfg_bypass(cfg_bypass), .cfg_invert(cfg_invert), .cfg_bitrev(cfg_bitrev),
    .cfg_swap(cfg_swap), .cfg_byte_mode(cfg_byte_mode), .cfg_dual(cfg_dual),
    .out_valid(out_valid), .out_data(out_data)
  );

  // Reference model built from the requirements: invert, mirror, exchange.
  function automatic logic [19:0] model(input logic [5:0] c, input logic [19:0] x);
    logic [19:0] y, t;
    int nslots;
    // c = {bypass, invert, bitrev, swap, byte_mode, dual}
    if (c[5]) return x;
    y = x;
    nslots = c[0] ? 2 : 1;
    for (int s = 0; s < nslots; s++)
      for (int b = 0; b < 10; b++)
        if (c[4] && (!c[1] || b < 8)) y[s*10+b] = ~y[s*10+b];
    if (c[3]) begin
      t = y;
      for (int s = 0; s < nslots; s++)
        for (int b = 0; b < 10; b++)
          if (c[1]) begin
            if (b < 8) y[s*10+b] = t[s*10+7-b];
          end else begin
            y[s*10+b] = t[s*10+9-b];
          end
    end
    if (c[0] && c[2]) y = {y[9:0], y[19:10]};
    return y;
  endfunction

  function automatic string tag_for(input logic [5:0] c);
    if (c[5]) return "R3";
    if (c[0] && c[2]) return "R8";
    if (!c[0] && c[2]) return "R9";
    if (c[1] && c[4]) return "R6";
    if (c[1] && c[3]) return "R7";
    if (c[4]) return "R4";
    if (c[3]) return "R5";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic run_word(input logic [5:0] c, input logic [19:0] x, input logic v);
    logic [19:0] first;
    {cfg_bypass, cfg_invert, cfg_bitrev, cfg_swap, cfg_byte_mode, cfg_dual} = c;
    in_data  = x;
    in_valid = v;
    @(negedge clk);
    check(tag_for(c), out_data, model(c, x));
    check("R2 valid", {19'd0, out_valid}, {19'd0, v});
    first    = out_data;
    in_data  = first;
    in_valid = ~v;
    @(negedge clk);
    check("R10 round trip", out_data, x);
  endtask

  initial begin
    int guard = 0;
    while (!done) begin
      @(posedge clk);
      guard++;
      if (guard > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    logic [19:0] pats[6];
    pats[0] = 20'h00000; pats[1] = 20'hFFFFF; pats[2] = 20'hA5C3E;
    pats[3] = 20'h5A3C1; pats[4] = 20'h00FFF; pats[5] = 20'hC0301;
    rst = 1'b1; in_valid = 1'b1; in_data = 20'hFFFFF;
    {cfg_bypass, cfg_invert, cfg_bitrev, cfg_swap, cfg_byte_mode, cfg_dual} = 6'b000001;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset data", out_data, 20'h0);
    check("R1 reset valid", {19'd0, out_valid}, 20'h0);
    rst = 1'b0;
    @(negedge clk);
    for (int c = 0; c < 64; c++) begin
      for (int b = 0; b < 20; b++)
        run_word(c[5:0], 20'd1 << b, b[0]);
      for (int p = 0; p < 6; p++)
        run_word(c[5:0], pats[p], p[0]);
    end
    // Explicit corner cases.
    run_word(6'b010010, 20'h00000, 1'b1);
    check("R6 side bits kept", out_data, 20'h00000);
    run_word(6'b000101, 20'h00001, 1'b1);
    done = 1;
    finish_run();
  end
endmodule